// File: doc/BRIEF.md
# Double-Buffered PWM Timer Channel

This block is one down-counting timer channel that produces a pulse-width-modulated output and a periodic interrupt. A programmable prescaler and a power-of-two divider turn the input clock into a counting tick enable. Each tick decrements a 32-bit working counter, and all logic runs on the single input clock.

Software never writes the working counter or the working compare register directly. It programs a count buffer and a compare buffer. Their contents reach the working registers in one of two ways: a manual-update control bit, or the automatic reload that happens each time the counter expires. The output rises when the counter steps down onto the compare value and falls again at reload, so the buffers set the period and the duty cycle. Software can swap in new values without disturbing the cycle in flight.

A small word-addressed register interface carries configuration, the buffers, a read-only view of the working counter and a sticky interrupt flag. The interrupt flag is cleared by writing one to it.

Top module: `pwm_timer_chan`

## Requirements
- R1: After reset, every readable register (addresses 0 to 5) reads zero, `pwm_out` is low and `irq_pulse` is low.
- R2: The tick period is (P+1)·2^S clocks. P is bits [7:0] of the clock register (address 1) and S is bits [10:8] of the same register. S codes above 4 behave as 4.
- R3: While running, the working counter (read at address 4) falls by one per tick. A tick that finds it at zero is the expiry tick. With auto-reload, expiry ticks recur every (B+1) ticks, where B is the count buffer (address 2).
- R4: While the manual-update bit (bit 1 of the control register, address 0) is 1, the working counter and compare are loaded from the buffers on every clock, and counting is suspended.
- R5: A write to the count buffer does not change the working counter until the next load.
- R6: The raw output level goes high on the tick that decrements the counter onto the compare value C (address 3). It goes low on an expiry tick or a manual load. Per auto-reload period the output is high for (C+1)·(P+1)·2^S clocks when C < B, and for 0 clocks otherwise.
- R7: Control bit 3 inverts `pwm_out`.
- R8: With control bit 4 set, each expiry tick produces a one-clock `irq_pulse` and sets the pending flag (bit 0 of address 5). With bit 4 clear, expiry ticks produce neither.
- R9: Writing 1 to bit 0 of address 5 clears the pending flag. Writing 0 leaves it unchanged.
- R10: With auto-reload (control bit 2) clear, the expiry tick leaves the counter at 0 and clears the start bit (control bit 0) in hardware. No further interrupt follows.
- R11: With the start bit clear, the working counter holds its value.
- R12: Address 4 is read-only. Writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| pwm_out | output | 1 | PWM output after optional inversion |
| irq_pulse | output | 1 | One-clock interrupt request |

## Verification
The embedded properties assume three things about the inputs. The prescaler and divider fields stay fixed while the channel runs. The start and manual-update bits are not both held on during measurement. A clock spent in manual update is not counted as a tick. The stimulus honours these assumptions: it stops the channel with a zero control write before it touches the clock register or the buffers. It loads the buffers with a manual-update write alone, and only then sets start, so every measured period starts from a known load. The duty and period sweeps take their timing windows from consecutive interrupt pulses, which keeps the checks independent of the start-up latency.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_CLKCFG = 3'd1,
    A_CNTBUF = 3'd2,
    A_CMPBUF = 3'd3,
    A_CNTOBS = 3'd4,
    A_IRQST  = 3'd5
  } reg_addr_e;

  // control word, LSB first: start, manual load, auto reload, invert, irq enable
  typedef struct packed {
    logic irq_en;
    logic invert;
    logic auto_rl;
    logic manual;
    logic start;
  } ctrl_t;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int PRE_W   = 8,
  parameter int SEL_W   = 3,
  parameter int NUM_DIV = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] prescale,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  localparam int DIVC_W = NUM_DIV - 1;
  localparam logic [SEL_W-1:0] MAX_SEL = SEL_W'(NUM_DIV - 1);

  logic [PRE_W-1:0]  pre_q, pre_n;
  logic [DIVC_W-1:0] div_q, div_n;
  logic [DIVC_W-1:0] mask;
  logic [SEL_W-1:0]  sel_eff;
  logic              pre_wrap;

  assign sel_eff = (div_sel > MAX_SEL) ? MAX_SEL : div_sel;

  generate
    for (genvar i = 0; i < DIVC_W; i++) begin : g_mask
      assign mask[i] = (sel_eff > SEL_W'(i));
    end
  endgenerate

  assign pre_wrap = run && (pre_q >= prescale);
  assign tick     = pre_wrap && ((div_q & mask) == mask);

  always_comb begin
    pre_n = pre_q;
    div_n = div_q;
    if (!run) begin
      pre_n = '0;
      div_n = '0;
    end else if (pre_wrap) begin
      pre_n = '0;
      div_n = tick ? '0 : div_q + DIVC_W'(1);
    end else begin
      pre_n = pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      div_q <= '0;
    end else begin
      pre_q <= pre_n;
      div_q <= div_n;
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (prescale != '0)) |=> !tick) else $error("tick gap"); // R2
  AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(!run) && (prescale != '0)) |-> !tick) else $error("restart"); // R2
endmodule

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_chan_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] cnt_obs,
  input  logic              zero_evt,
  input  logic              oneshot_done,
  output ctrl_t             ctrl,
  output logic [PRE_W-1:0]  prescale,
  output logic [SEL_W-1:0]  div_sel,
  output logic [DATA_W-1:0] cnt_buf,
  output logic [DATA_W-1:0] cmp_buf,
  output logic              irq_pulse
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl_q, ctrl_n;
  logic [PRE_W-1:0]  pre_q, pre_n;
  logic [SEL_W-1:0]  sel_q, sel_n;
  logic [DATA_W-1:0] cbuf_q, cbuf_n;
  logic [DATA_W-1:0] mbuf_q, mbuf_n;
  logic              pend_q, pend_n;
  logic              irq_q, irq_n;
  logic              irq_set, irq_clr;

  assign irq_set = zero_evt && ctrl_q.irq_en;
  assign irq_clr = wr && (addr == A_IRQST) && wdata[0];

  always_comb begin
    ctrl_n = ctrl_q;
    pre_n  = pre_q;
    sel_n  = sel_q;
    cbuf_n = cbuf_q;
    mbuf_n = mbuf_q;
    if (wr) begin
      case (addr)
        A_CTRL:   ctrl_n = ctrl_t'(wdata[CTRL_W-1:0]);
        A_CLKCFG: begin
          pre_n = wdata[PRE_W-1:0];
          sel_n = wdata[PRE_W+SEL_W-1:PRE_W];
        end
        A_CNTBUF: cbuf_n = wdata;
        A_CMPBUF: mbuf_n = wdata;
        default:  ;
      endcase
    end
    if (oneshot_done) ctrl_n.start = 1'b0;
    pend_n = (pend_q && !irq_clr) || irq_set;
    irq_n  = irq_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pre_q  <= '0;
      sel_q  <= '0;
      cbuf_q <= '0;
      mbuf_q <= '0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      pre_q  <= pre_n;
      sel_q  <= sel_n;
      cbuf_q <= cbuf_n;
      mbuf_q <= mbuf_n;
      pend_q <= pend_n;
      irq_q  <= irq_n;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:   rdata[CTRL_W-1:0] = ctrl_q;
      A_CLKCFG: begin
        rdata[PRE_W-1:0]             = pre_q;
        rdata[PRE_W+SEL_W-1:PRE_W]   = sel_q;
      end
      A_CNTBUF: rdata = cbuf_q;
      A_CMPBUF: rdata = mbuf_q;
      A_CNTOBS: rdata = cnt_obs;
      A_IRQST:  rdata[0] = pend_q;
      default:  rdata = '0;
    endcase
  end

  assign ctrl      = ctrl_q;
  assign prescale  = pre_q;
  assign div_sel   = sel_q;
  assign cnt_buf   = cbuf_q;
  assign cmp_buf   = mbuf_q;
  assign irq_pulse = irq_q;

  AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> pend_q) else $error("irq without pending"); // R8
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !irq_set) |=> !pend_q) else $error("w1c"); // R9
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    oneshot_done |=> !ctrl_q.start) else $error("one-shot stop"); // R10
  AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.irq_en) |=> !irq_q) else $error("irq while disabled"); // R8
endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             manual,
  input  logic             auto_rl,
  input  logic             invert,
  input  logic [CNT_W-1:0] cnt_buf,
  input  logic [CNT_W-1:0] cmp_buf,
  output logic [CNT_W-1:0] cnt_obs,
  output logic             pwm_out,
  output logic             zero_evt,
  output logic             oneshot_done
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] cmp_q, cmp_n;
  logic [CNT_W-1:0] cnt_dec;
  logic             raw_q, raw_n;
  logic             step;

  assign step         = tick && start && !manual;
  assign zero_evt     = step && (cnt_q == '0);
  assign oneshot_done = zero_evt && !auto_rl;
  assign cnt_dec      = cnt_q - CNT_W'(1);

  always_comb begin
    cnt_n = cnt_q;
    cmp_n = cmp_q;
    raw_n = raw_q;
    if (manual) begin
      cnt_n = cnt_buf;
      cmp_n = cmp_buf;
      raw_n = 1'b0;
    end else if (zero_evt) begin
      raw_n = 1'b0;
      if (auto_rl) begin
        cnt_n = cnt_buf;
        cmp_n = cmp_buf;
      end
    end else if (step) begin
      cnt_n = cnt_dec;
      if (cnt_dec == cmp_q) raw_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '0;
      raw_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      cmp_q <= cmp_n;
      raw_q <= raw_n;
    end
  end

  assign cnt_obs = cnt_q;
  assign pwm_out = raw_q ^ invert;

  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))) else $error("decrement"); // R3
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && auto_rl) |=> (cnt_q == $past(cnt_buf) && cmp_q == $past(cmp_buf))) else $error("reload"); // R3
  AST_MANUAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    manual |=> (cnt_q == $past(cnt_buf) && !raw_q)) else $error("manual load"); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !manual) |=> $stable(cnt_q)) else $error("hold"); // R11
  AST_PWM_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !manual) |=> $stable(raw_q)) else $error("pwm glitch"); // R6
  AST_ONESHOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    oneshot_done |=> (cnt_q == '0)) else $error("one-shot zero"); // R10
endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int PRE_W   = 8,
  parameter int SEL_W   = 3,
  parameter int NUM_DIV = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              pwm_out,
  output logic              irq_pulse
);
  logic             rst_meta, rst_sync_n;
  ctrl_t            ctrl;
  logic [PRE_W-1:0] prescale;
  logic [SEL_W-1:0] div_sel;
  logic [CNT_W-1:0] cnt_buf, cmp_buf, cnt_obs;
  logic             tick, run, zero_evt, oneshot_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign run = ctrl.start && !ctrl.manual;

  pwm_chan_regs #(.DATA_W(CNT_W), .PRE_W(PRE_W), .SEL_W(SEL_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .wr           (reg_wr),
    .addr         (reg_addr),
    .wdata        (reg_wdata),
    .rdata        (reg_rdata),
    .cnt_obs      (cnt_obs),
    .zero_evt     (zero_evt),
    .oneshot_done (oneshot_done),
    .ctrl         (ctrl),
    .prescale     (prescale),
    .div_sel      (div_sel),
    .cnt_buf      (cnt_buf),
    .cmp_buf      (cmp_buf),
    .irq_pulse    (irq_pulse)
  );

  pwm_tick_gen #(.PRE_W(PRE_W), .SEL_W(SEL_W), .NUM_DIV(NUM_DIV)) u_tick (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (run),
    .prescale (prescale),
    .div_sel  (div_sel),
    .tick     (tick)
  );

  pwm_chan_core #(.CNT_W(CNT_W)) u_core (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .tick         (tick),
    .start        (ctrl.start),
    .manual       (ctrl.manual),
    .auto_rl      (ctrl.auto_rl),
    .invert       (ctrl.invert),
    .cnt_buf      (cnt_buf),
    .cmp_buf      (cmp_buf),
    .cnt_obs      (cnt_obs),
    .pwm_out      (pwm_out),
    .zero_evt     (zero_evt),
    .oneshot_done (oneshot_done)
  );
endmodule

// File: tb/pwm_timer_chan_test.sv
`timescale 1ns/1ps
module pwm_timer_chan_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        pwm_out;
  logic        irq_pulse;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pwm_timer_chan uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out),
    .irq_pulse(irq_pulse)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic count_irq(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq_pulse) c++;
    end
  endtask

  // clocks between two interrupt pulses and high clocks inside that window
  task automatic measure(output int per, output int hi);
    int guard = 0;
    per = 0; hi = 0;
    do begin @(negedge clk); guard++; end while (!irq_pulse && guard < 5000);
    do begin
      if (pwm_out) hi++;
      per++;
      @(negedge clk);
    end while (!irq_pulse && per < 5000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d, o1, o2;
    int per, hi, c, t, sel_e;
    int pv[2]   = '{0, 2};
    int bv[3]   = '{0, 1, 3};
    int sv[6]   = '{0, 1, 2, 3, 4, 7};
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd_reg(3'(a), d);
      chk("R1 reset register", d, 32'd0);
    end
    chk("R1 pwm_out low", {31'd0, pwm_out}, 32'd0);
    chk("R1 irq_pulse low", {31'd0, irq_pulse}, 32'd0);

    // R7 inversion while stopped
    wr_reg(3'd0, 32'h08);
    #1 chk("R7 inverted idle output", {31'd0, pwm_out}, 32'd1);
    wr_reg(3'd0, 32'h00);
    #1 chk("R7 normal idle output", {31'd0, pwm_out}, 32'd0);

    // R4 manual load, R11 hold, R5 buffer isolation, R12 read-only
    wr_reg(3'd2, 32'd100);
    wr_reg(3'd3, 32'd50);
    wr_reg(3'd0, 32'h02);
    wr_reg(3'd0, 32'h00);
    rd_reg(3'd4, d);
    chk("R4 manual load visible", d, 32'd100);
    repeat (50) @(negedge clk);
    rd_reg(3'd4, d);
    chk("R11 counter holds when stopped", d, 32'd100);
    wr_reg(3'd2, 32'd7);
    rd_reg(3'd4, d);
    chk("R5 buffer write isolated", d, 32'd100);
    wr_reg(3'd4, 32'd5);
    rd_reg(3'd4, d);
    chk("R12 observation read-only", d, 32'd100);

    // R3 countdown rate: P=9, S=0 -> one tick per 10 clocks
    wr_reg(3'd1, 32'd9);
    wr_reg(3'd0, 32'h01);
    repeat (20) @(negedge clk);
    rd_reg(3'd4, o1);
    repeat (29) @(negedge clk);
    rd_reg(3'd4, o2);
    chk("R3 counts one per tick", o1 - o2, 32'd3);
    wr_reg(3'd0, 32'h00);

    // R2 R3 R6 sweep of prescale, divider, count and compare
    foreach (pv[ip]) foreach (sv[is]) foreach (bv[ib]) foreach (bv[ic]) begin
      sel_e = (sv[is] > 4) ? 4 : sv[is];
      t = (pv[ip] + 1) * (1 << sel_e);
      wr_reg(3'd0, 32'h00);
      wr_reg(3'd1, 32'((sv[is] << 8) | pv[ip]));
      wr_reg(3'd2, 32'(bv[ib]));
      wr_reg(3'd3, 32'(bv[ic]));
      wr_reg(3'd0, 32'h16);
      wr_reg(3'd0, 32'h15);
      measure(per, hi);
      chk("R2/R3 period", 32'(per), 32'((bv[ib] + 1) * t));
      chk("R6 high time", 32'(hi), 32'((bv[ic] < bv[ib]) ? (bv[ic] + 1) * t : 0));
    end
    wr_reg(3'd0, 32'h00);
    wr_reg(3'd5, 32'h1);

    // R10 one-shot with R8 interrupt and R9 clear semantics
    wr_reg(3'd1, 32'd0);
    wr_reg(3'd2, 32'd2);
    wr_reg(3'd3, 32'd9);
    wr_reg(3'd0, 32'h12);
    wr_reg(3'd0, 32'h11);
    count_irq(40, c);
    chk("R10 single interrupt", 32'(c), 32'd1);
    rd_reg(3'd0, d);
    chk("R10 start cleared", d, 32'h10);
    rd_reg(3'd4, d);
    chk("R10 counter at zero", d, 32'd0);
    rd_reg(3'd5, d);
    chk("R8 pending set", d, 32'd1);
    wr_reg(3'd5, 32'h0);
    rd_reg(3'd5, d);
    chk("R9 write zero keeps pending", d, 32'd1);
    wr_reg(3'd5, 32'h1);
    rd_reg(3'd5, d);
    chk("R9 write one clears", d, 32'd0);

    // R8 interrupt disabled
    wr_reg(3'd2, 32'd1);
    wr_reg(3'd0, 32'h06);
    wr_reg(3'd0, 32'h05);
    count_irq(40, c);
    chk("R8 no pulse when disabled", 32'(c), 32'd0);
    rd_reg(3'd5, d);
    chk("R8 no pending when disabled", d, 32'd0);
    wr_reg(3'd0, 32'h00);

    summary();
    $finish;
  end
endmodule